// File: doc/BRIEF.md
# Variable Pulse Fault Injector

This block sits in series with a bus of digital signal lines and corrupts them on purpose, to model repeating bursts of interference. A period counter produces a select window. The window repeats at a period set at run time, and its width is also set at run time. While the window is active, each line's output multiplexer selects a faulty value in place of the true input. The faulty value depends on a two-bit code for that line: no fault, inverted, forced low, or forced high. All lines share one window, so a group of lines is hit in the same cycles and the result is a multi-line fault.

In probabilistic mode, a pseudo-random generator is compared against a threshold at the start of each window. The whole window then either corrupts the lines or leaves them untouched. This models sporadic faults on on-chip wires. An illegal width/period pair raises an error flag and turns injection off.

Top module: `pulse_fault_injector`

## Requirements
- R1: `config_error` is high exactly when `cfg_width` is 0 or `cfg_width` >= `cfg_period`, and no line is altered while it is high.
- R2: In every cycle with no active fault window (enable low, error raised, or outside the window), `sig_out` equals `sig_in`.
- R3: With enable high and a legal setup, a cycle counter starts at 0 in the first cycle in which enable is seen high. It wraps to 0 after `cfg_period` cycles. The window covers counts 0 to `cfg_width`-1.
- R4: The mode of line i is `cfg_mode[2i+1:2i]`. Code 00 leaves the line untouched, 01 inverts it, 10 forces it to 0 and 11 forces it to 1 during a window.
- R5: All lines use the same window, so every line with a non-zero code is altered in exactly the same cycles.
- R6: With `cfg_prob_en` high, the decision is made at count 0. The window applies only if the generator value is below `cfg_threshold` at that count, and the decision holds for the whole window. A threshold of 0 never injects.
- R7: The generator is a 16-bit right-shifting Galois register with feedback mask 0xB400 and reset value 0xACE1. It advances once at each count-0 cycle while running, in both modes.
- R8: `inject_active` is high exactly in the cycles in which at least one line with a non-zero code is being altered.
- R9: During reset the counter is 0 and the generator holds its reset value. With enable low, `sig_out` follows `sig_in` and `inject_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Turns on the period counter |
| cfg_prob_en | input | 1 | Gates each window by the random threshold test |
| cfg_width | input | CW | Window width in cycles |
| cfg_period | input | CW | Repeat period in cycles |
| cfg_threshold | input | 16 | Probability threshold |
| cfg_mode | input | 2*LINES | Per-line fault codes |
| sig_in | input | LINES | True line values |
| sig_out | output | LINES | Line values after injection |
| inject_active | output | 1 | High while any line is being altered |
| config_error | output | 1 | Illegal width/period pair |

## Verification
The main function is tried with random line values under random legal widths and periods, and under random mixes of per-line codes. These runs tell the window's placement and length apart from the choice of faulty value on each line. Directed segments with a width of 1, a width of period-1 and a width equal to the period probe the edges of the window and the error test. A zero threshold, a full threshold and random thresholds in probabilistic mode tell the per-window decision apart from a per-cycle one, and check that the generator sequence stays aligned. An all-force-high segment shows that the lines switch together, and an all-untouched segment shows that the activity flag stays quiet when no line is altered.

// File: rtl/fi_pkg.sv
package fi_pkg;
  typedef enum logic [1:0] {
    FI_PASS = 2'b00,
    FI_FLIP = 2'b01,
    FI_LOW  = 2'b10,
    FI_HIGH = 2'b11
  } fi_mode_e;

  localparam int          RND_W    = 16;
  localparam logic [15:0] RND_SEED = 16'hACE1;
  localparam logic [15:0] RND_MASK = 16'hB400;
endpackage

// File: rtl/fi_period_gen.sv
module fi_period_gen #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] width,
  output logic          in_window,
  output logic          at_start
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)                                cnt_d = '0;
    else if (cnt_q >= period - {{(CW-1){1'b0}}, 1'b1}) cnt_d = '0;
    else                                     cnt_d = cnt_q + {{(CW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign in_window = run && (cnt_q < width);
  assign at_start  = run && (cnt_q == '0);
endmodule

// File: rtl/fi_lfsr_gate.sv
module fi_lfsr_gate
  import fi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             at_start,
  input  logic             in_window,
  input  logic             prob_en,
  input  logic [RND_W-1:0] threshold,
  output logic             fire
);
  logic [RND_W-1:0] lfsr_q, lfsr_d;
  logic             gate_q, gate_d;
  logic             hit_now;

  assign hit_now = !prob_en || (lfsr_q < threshold);

  always_comb begin
    lfsr_d = lfsr_q;
    gate_d = gate_q;
    if (at_start) begin
      lfsr_d = (lfsr_q >> 1) ^ (lfsr_q[0] ? RND_MASK : '0);
      gate_d = hit_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= RND_SEED;
      gate_q <= 1'b0;
    end else begin
      lfsr_q <= lfsr_d;
      gate_q <= gate_d;
    end
  end

  assign fire = in_window && (at_start ? hit_now : gate_q);
endmodule

// File: rtl/fi_line_mux.sv
module fi_line_mux
  import fi_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic [LINES-1:0]   sig_in,
  input  logic [2*LINES-1:0] mode,
  input  logic               fire,
  output logic [LINES-1:0]   sig_out,
  output logic               any_hit
);
  logic [LINES-1:0] altered;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    fi_mode_e m;
    logic     bad_val;
    assign m = fi_mode_e'(mode[2*i +: 2]);
    always_comb begin
      unique case (m)
        FI_FLIP: bad_val = ~sig_in[i];
        FI_LOW:  bad_val = 1'b0;
        FI_HIGH: bad_val = 1'b1;
        default: bad_val = sig_in[i];
      endcase
    end
    assign altered[i] = fire && (m != FI_PASS);
    assign sig_out[i] = altered[i] ? bad_val : sig_in[i];
  end

  assign any_hit = |altered;
endmodule

// File: rtl/pulse_fault_injector.sv
module pulse_fault_injector
  import fi_pkg::*;
#(
  parameter int LINES = 8,
  parameter int CW    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic               cfg_prob_en,
  input  logic [CW-1:0]      cfg_width,
  input  logic [CW-1:0]      cfg_period,
  input  logic [RND_W-1:0]   cfg_threshold,
  input  logic [2*LINES-1:0] cfg_mode,
  input  logic [LINES-1:0]   sig_in,
  output logic [LINES-1:0]   sig_out,
  output logic               inject_active,
  output logic               config_error
);
  logic run, in_window, at_start, fire;

  assign config_error = (cfg_width == '0) || (cfg_width >= cfg_period);
  assign run          = cfg_enable && !config_error;

  fi_period_gen #(.CW(CW)) u_period (
    .clk(clk), .rst_n(rst_n), .run(run), .period(cfg_period),
    .width(cfg_width), .in_window(in_window), .at_start(at_start)
  );

  fi_lfsr_gate u_gate (
    .clk(clk), .rst_n(rst_n), .at_start(at_start), .in_window(in_window),
    .prob_en(cfg_prob_en), .threshold(cfg_threshold), .fire(fire)
  );

  fi_line_mux #(.LINES(LINES)) u_mux (
    .sig_in(sig_in), .mode(cfg_mode), .fire(fire),
    .sig_out(sig_out), .any_hit(inject_active)
  );
endmodule

// File: rtl/fi_checker.sv
module fi_checker
  import fi_pkg::*;
#(
  parameter int LINES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_enable,
  input logic               cfg_prob_en,
  input logic [RND_W-1:0]   cfg_threshold,
  input logic [2*LINES-1:0] cfg_mode,
  input logic [LINES-1:0]   sig_in,
  input logic [LINES-1:0]   sig_out,
  input logic               inject_active,
  input logic               config_error
);
  logic [LINES-1:0] hi_mask, lo_mask;

  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      hi_mask[i] = (cfg_mode[2*i +: 2] == 2'b11);
      lo_mask[i] = (cfg_mode[2*i +: 2] == 2'b10);
    end
  end

  // R1
  err_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    config_error |-> (!inject_active && sig_out == sig_in));

  // R2
  quiet_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inject_active |-> (sig_out == sig_in));

  // R4
  forced_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inject_active |-> (((sig_out & hi_mask) == hi_mask) && ((sig_out & lo_mask) == '0)));

  // R6
  zero_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_prob_en && cfg_threshold == '0) |-> !inject_active);

  // R8
  active_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inject_active |-> (cfg_enable && cfg_mode != '0));
endmodule

bind pulse_fault_injector fi_checker #(.LINES(LINES)) u_fi_checker (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_prob_en(cfg_prob_en),
  .cfg_threshold(cfg_threshold), .cfg_mode(cfg_mode), .sig_in(sig_in),
  .sig_out(sig_out), .inject_active(inject_active), .config_error(config_error)
);

// File: tb/pulse_fault_injector_bench.sv
module pulse_fault_injector_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 8;
  localparam int CW = 16;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               cfg_enable, cfg_prob_en;
  logic [CW-1:0]      cfg_width, cfg_period;
  logic [15:0]        cfg_threshold;
  logic [2*LINES-1:0] cfg_mode;
  logic [LINES-1:0]   sig_in, sig_out;
  logic               inject_active, config_error;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model state
  int         mcnt;
  bit         mgate;
  logic [15:0] mlfsr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_fault_injector #(.LINES(LINES), .CW(CW)) u_pulse_fault_injector (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_prob_en(cfg_prob_en),
    .cfg_width(cfg_width), .cfg_period(cfg_period), .cfg_threshold(cfg_threshold),
    .cfg_mode(cfg_mode), .sig_in(sig_in), .sig_out(sig_out),
    .inject_active(inject_active), .config_error(config_error)
  );

  // R7: generator step
  function automatic logic [15:0] step(input logic [15:0] v);
    return (v >> 1) ^ (v[0] ? 16'hB400 : 16'h0000);
  endfunction

  function automatic bit m_err();
    return (cfg_width == 0) || (cfg_width >= cfg_period);
  endfunction

  function automatic bit m_run();
    return cfg_enable && !m_err();
  endfunction

  function automatic bit m_hit();
    return !cfg_prob_en || (mlfsr < cfg_threshold);
  endfunction

  function automatic bit m_fire();
    bit st;
    st = m_run() && mcnt == 0;
    return m_run() && (mcnt < int'(cfg_width)) && (st ? m_hit() : mgate);
  endfunction

  function automatic logic [LINES-1:0] m_out(input bit f);
    logic [LINES-1:0] o;
    for (int i = 0; i < LINES; i++) begin
      case (cfg_mode[2*i +: 2])
        2'b01:   o[i] = f ? ~sig_in[i] : sig_in[i];
        2'b10:   o[i] = f ? 1'b0 : sig_in[i];
        2'b11:   o[i] = f ? 1'b1 : sig_in[i];
        default: o[i] = sig_in[i];
      endcase
    end
    return o;
  endfunction

  task automatic check_now();
    bit f;
    logic [LINES-1:0] eo;
    bit ea;
    f  = m_fire();
    eo = m_out(f);
    ea = f && (cfg_mode != '0);
    checks++;
    if (sig_out !== eo) begin
      errors++;
      $display("FAIL %s sig_out: actual %h expected %h", f ? (cfg_prob_en ? "R6" : "R4") : "R2", sig_out, eo);
    end
    checks++;
    if (inject_active !== ea) begin
      errors++;
      $display("FAIL R8 inject_active: actual %b expected %b", inject_active, ea);
    end
    checks++;
    if (config_error !== m_err()) begin
      errors++;
      $display("FAIL R1 config_error: actual %b expected %b", config_error, m_err());
    end
  endtask

  task automatic advance();
    bit run, st, h;
    run = m_run();
    st  = run && mcnt == 0;
    h   = m_hit();
    @(posedge clk);
    if (st) begin
      mgate = h;
      mlfsr = step(mlfsr);
    end
    if (!run) mcnt = 0;
    else if (mcnt >= int'(cfg_period) - 1) mcnt = 0;
    else mcnt = mcnt + 1;
    @(negedge clk);
  endtask

  task automatic seg(input bit en, input bit pe, input int w, input int p,
                     input logic [15:0] thr, input logic [2*LINES-1:0] md, input int n);
    cfg_enable = en; cfg_prob_en = pe;
    cfg_width = CW'(w); cfg_period = CW'(p);
    cfg_threshold = thr; cfg_mode = md;
    for (int k = 0; k < n; k++) begin
      sig_in = LINES'($urandom);
      #1;
      check_now();
      advance();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    cfg_enable = 0; cfg_prob_en = 0; cfg_width = 3; cfg_period = 8;
    cfg_threshold = 0; cfg_mode = '1; sig_in = 8'hA5;
    mcnt = 0; mgate = 0; mlfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    // R9: reset state
    checks++;
    if (sig_out !== sig_in || inject_active !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset: actual %h/%b expected %h/0", sig_out, inject_active, sig_in);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R3: window edges, width 1 and width period-1
    seg(1, 0, 1, 2, 0, {LINES{2'b01}}, 20);
    seg(1, 0, 6, 7, 0, {LINES{2'b10}}, 30);
    // R1: illegal setups
    seg(1, 0, 0, 5, 0, '1, 12);
    seg(1, 0, 5, 5, 0, '1, 12);
    seg(1, 0, 9, 4, 0, '1, 12);
    // R5: all lines forced high together
    seg(1, 0, 3, 9, 0, '1, 30);
    // R8: all codes 00, flag stays low
    seg(1, 0, 3, 6, 0, '0, 20);
    // R9-like disable returns pass-through
    seg(0, 0, 3, 6, 0, '1, 10);
    // R6: zero threshold never injects; full threshold nearly always
    seg(1, 1, 2, 5, 16'h0000, '1, 40);
    seg(1, 1, 2, 5, 16'hFFFF, '1, 40);
    // R6/R7: random thresholds exercise generator sequence
    seg(1, 1, 3, 4, 16'h8000, {LINES{2'b01}}, 200);

    // constrained random segments
    for (int s = 0; s < 60; s++) begin
      int p, w;
      p = 2 + int'($urandom % 20);
      w = ($urandom % 8 == 0) ? int'($urandom % 24) : 1 + int'($urandom % (p - 1));
      seg(($urandom % 6) != 0, $urandom % 2 == 1, w, p, 16'($urandom),
          16'($urandom), 20 + int'($urandom % 80));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule